// File: doc/BRIEF.md
# SPI Ferroelectric Memory Identification Probe

This block runs the start-up discovery sequence for a ferroelectric memory on an SPI bus. When `start` is pulsed, it acts as an SPI master in mode 0, with the clock idling low and data sent MSB first. It performs up to three chip-select framed transactions.

- **Status read.** It first reads the status byte and requires the device to be idle.
- **Identification read.** It then reads a nine-byte identification string. It checks the vendor byte and turns the density byte into a byte capacity and an address length.
- **Serial number read.** If the last identification byte is nonzero, it reads an eight-byte serial number and stores it in reversed byte order.

The outcome appears on `done`, `valid`, `err`, `dev_size`, `addr_bytes` and `serial`. These hold until the next `start`. The rest of the system reads the results once `done` is high and uses them to configure normal memory traffic. This block does not perform that traffic.

The controller has these states:
- **IDLE:** waits for `start`.
- **ST_OP, ST_RX:** send opcode 0x05 and receive the status byte.
- **GAP_A:** one cycle with chip select high.
- **ID_OP, ID_RX:** send opcode 0x9F and receive nine bytes.
- **GAP_B:** one cycle with chip select high.
- **SN_OP, SN_RX:** send opcode 0xC3 and receive eight bytes.
- **FINISH:** success.
- **ABORT:** failure.

The controller has these transitions:
- IDLE, FINISH and ABORT go to ST_OP on `start`.
- Each *_OP state goes to its *_RX state when the opcode byte completes.
- ST_RX goes to ABORT if status bit 0 is set; otherwise it goes to GAP_A.
- GAP_A goes to ID_OP, and GAP_B goes to SN_OP.
- ID_RX, after its last byte, goes to one of:
  - ABORT, on a bad vendor or a bad density;
  - GAP_B, when the serial flag is set;
  - FINISH, when the serial flag is clear.
- SN_RX goes to FINISH after its last byte.

Top module: `fram_probe`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, and `done`, `valid`, `err`, `dev_size`, `addr_bytes` and `serial` are all 0.
- R2: Transfers use SPI mode 0 with MSB first. `spi_sclk` stays low whenever `spi_cs_n` is high. Each transaction starts with its opcode byte, and `spi_cs_n` returns high between transactions.
- R3: The first transaction sends opcode 0x05 and clocks in one status byte. If status bit 0 (busy) is 1, the probe ends with `err`=1, and no further transaction takes place.
- R4: The identification transaction sends opcode 0x9F and clocks in exactly nine bytes, numbered 0 to 8.
- R5: If identification byte 6 is not 0xC2, the probe ends with `err`=2. This check takes priority over the density check.
- R6: If identification byte 7 lies outside 0x21 to 0x26, the probe ends with `err`=3.
- R7: On success, `dev_size` = 2^(byte7 - 0x21 + 4) * 1024 bytes.
- R8: On success, `addr_bytes` is 3 when `dev_size` exceeds 65536, and 2 otherwise.
- R9: If identification byte 8 is nonzero, a transaction with opcode 0xC3 clocks in eight bytes. The k-th received byte (k = 0 to 7) is placed in `serial[8*(7-k)+7 : 8*(7-k)]`.
- R10: If identification byte 8 is zero, no 0xC3 transaction takes place, and `serial` stays all zeros.
- R11: `valid` rises only together with `done` and `err`=0, after every required read has finished. A new `start` clears `valid`, `done`, `err` and `serial` while the next probe runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that begins a probe |
| spi_sclk | output | 1 | SPI serial clock (idles low) |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Master-out serial data |
| spi_miso | input | 1 | Master-in serial data |
| done | output | 1 | Probe finished, whether it passed or failed |
| valid | output | 1 | Probe finished successfully |
| err | output | 2 | Result code: 0 none, 1 busy, 2 vendor, 3 density |
| dev_size | output | 20 | Decoded capacity in bytes |
| addr_bytes | output | 2 | Address length in bytes (2 or 3) |
| serial | output | 64 | Byte-reversed serial number |

## Verification
The bench sweeps the density byte across both ends of the accepted range and one code past each end. It also tests the 64 KiB / 128 KiB pair that straddles the address-length threshold. A design with an off-by-one in the exponent, or with `>=` in place of `>`, would report the wrong size or a third address byte for a 64 KiB part.

A case with both a bad vendor and a bad density tests the error priority. A busy status must stop the probe after a single transaction.

The serial number carries a distinct value in every byte, so any reversal mistake shows. A flag of zero must produce no 0xC3 transaction and an all-zero serial. A design that ignored the flag would add a third transaction to the count.

// File: rtl/fprobe_pkg.sv
package fprobe_pkg;
    localparam logic [7:0] OP_STATUS = 8'h05;
    localparam logic [7:0] OP_IDENT  = 8'h9F;
    localparam logic [7:0] OP_SERIAL = 8'hC3;
    localparam logic [7:0] DENS_LO   = 8'h21;
    localparam logic [7:0] DENS_HI   = 8'h26;
    localparam int         BASE_EXP  = 4;
    localparam int         KIB_SHIFT = 10;
    localparam int         SIZE_W    = int'(DENS_HI - DENS_LO) + BASE_EXP + KIB_SHIFT + 1;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_BUSY    = 2'd1,
        ERR_VENDOR  = 2'd2,
        ERR_DENSITY = 2'd3
    } perr_e;

    typedef enum logic [3:0] {
        S_IDLE, S_ST_OP, S_ST_RX, S_GAP_A, S_ID_OP, S_ID_RX,
        S_GAP_B, S_SN_OP, S_SN_RX, S_FINISH, S_ABORT
    } pstate_e;
endpackage

// File: rtl/fprobe_shifter.sv
module fprobe_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [BITS-1:0] tx,
    input  logic            miso,
    output logic            sclk,
    output logic            mosi,
    output logic            busy,
    output logic            done,
    output logic [BITS-1:0] rx
);
    localparam int CW = $clog2(BITS);

    logic [BITS-1:0] tx_sh;
    logic [BITS-1:0] rx_sh;
    logic [CW-1:0]   bit_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh   <= '0;
            rx_sh   <= '0;
            bit_cnt <= '0;
            sclk    <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go && !busy) begin
                tx_sh   <= tx;
                bit_cnt <= '0;
                busy    <= 1'b1;
            end else if (busy) begin
                if (!sclk) begin
                    sclk  <= 1'b1;
                    rx_sh <= {rx_sh[BITS-2:0], miso};
                end else begin
                    sclk  <= 1'b0;
                    tx_sh <= {tx_sh[BITS-2:0], 1'b0};
                    if (bit_cnt == CW'(BITS-1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            end
        end
    end

    assign mosi = tx_sh[BITS-1];
    assign rx   = rx_sh;

    AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk); // R2
endmodule

// File: rtl/fprobe_id_decode.sv
module fprobe_id_decode
    import fprobe_pkg::*;
#(
    parameter logic [7:0] VENDOR_CODE = 8'hC2
) (
    input  logic [7:0]        vendor,
    input  logic [7:0]        density,
    output logic              vendor_ok,
    output logic              density_ok,
    output logic [SIZE_W-1:0] size,
    output logic [1:0]        addr_len
);
    localparam logic [SIZE_W-1:0] ONE       = SIZE_W'(1);
    localparam logic [SIZE_W-1:0] ADDR2_MAX = SIZE_W'(65536);

    logic [7:0] exponent;

    always_comb begin
        vendor_ok  = (vendor == VENDOR_CODE);
        density_ok = (density >= DENS_LO) && (density <= DENS_HI);
        exponent   = density - DENS_LO + 8'(BASE_EXP + KIB_SHIFT);
        size       = density_ok ? (ONE << exponent) : '0;
        addr_len   = (size > ADDR2_MAX) ? 2'd3 : 2'd2;
    end
endmodule

// File: rtl/fram_probe.sv
module fram_probe
    import fprobe_pkg::*;
#(
    parameter int         ID_BYTES    = 9,
    parameter int         SN_BYTES    = 8,
    parameter logic [7:0] VENDOR_CODE = 8'hC2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    output logic                  spi_sclk,
    output logic                  spi_cs_n,
    output logic                  spi_mosi,
    input  logic                  spi_miso,
    output logic                  done,
    output logic                  valid,
    output logic [1:0]            err,
    output logic [SIZE_W-1:0]     dev_size,
    output logic [1:0]            addr_bytes,
    output logic [SN_BYTES*8-1:0] serial
);
    localparam int CNT_W      = $clog2((ID_BYTES > SN_BYTES ? ID_BYTES : SN_BYTES) + 1);
    localparam int VENDOR_IDX = ID_BYTES - 3;
    localparam int DENS_IDX   = ID_BYTES - 2;
    localparam int LAST_ID    = ID_BYTES - 1;
    localparam int LAST_SN    = SN_BYTES - 1;

    pstate_e state, nstate;
    logic [CNT_W-1:0]    cnt;
    logic [7:0]          vendor_q, dens_q;
    logic                sn_flag_q;
    perr_e               err_q;
    logic [SIZE_W-1:0]   size_q;
    logic [1:0]          addr_q;
    logic [SN_BYTES*8-1:0] serial_q;

    logic       xfer, eng_go, eng_busy, eng_done;
    logic [7:0] tx_byte, eng_rx;
    logic       vendor_ok, density_ok;
    logic [SIZE_W-1:0] dec_size;
    logic [1:0] dec_addr;
    logic       launch;

    assign xfer = (state == S_ST_OP) || (state == S_ST_RX) || (state == S_ID_OP) ||
                  (state == S_ID_RX) || (state == S_SN_OP) || (state == S_SN_RX);
    assign eng_go = xfer && !eng_busy && !eng_done;
    assign launch = start && ((state == S_IDLE) || (state == S_FINISH) || (state == S_ABORT));

    always_comb begin
        unique case (state)
            S_ST_OP: tx_byte = OP_STATUS;
            S_ID_OP: tx_byte = OP_IDENT;
            S_SN_OP: tx_byte = OP_SERIAL;
            default: tx_byte = 8'h00;
        endcase
    end

    fprobe_shifter #(.BITS(8)) u_shift (
        .clk(clk), .rst_n(rst_n), .go(eng_go), .tx(tx_byte), .miso(spi_miso),
        .sclk(spi_sclk), .mosi(spi_mosi), .busy(eng_busy), .done(eng_done), .rx(eng_rx)
    );

    fprobe_id_decode #(.VENDOR_CODE(VENDOR_CODE)) u_dec (
        .vendor(vendor_q), .density(dens_q), .vendor_ok(vendor_ok),
        .density_ok(density_ok), .size(dec_size), .addr_len(dec_addr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // transitions
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE, S_FINISH, S_ABORT: if (start) nstate = S_ST_OP;
            S_ST_OP: if (eng_done) nstate = S_ST_RX;
            S_ST_RX: if (eng_done) nstate = eng_rx[0] ? S_ABORT : S_GAP_A;
            S_GAP_A: nstate = S_ID_OP;
            S_ID_OP: if (eng_done) nstate = S_ID_RX;
            S_ID_RX: if (eng_done && cnt == CNT_W'(LAST_ID)) begin
                if (!vendor_ok || !density_ok) nstate = S_ABORT;
                else if (eng_rx != 8'h00)      nstate = S_GAP_B;
                else                           nstate = S_FINISH;
            end
            S_GAP_B: nstate = S_SN_OP;
            S_SN_OP: if (eng_done) nstate = S_SN_RX;
            S_SN_RX: if (eng_done && cnt == CNT_W'(LAST_SN)) nstate = S_FINISH;
            default: nstate = S_IDLE;
        endcase
    end

    // captured results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0; vendor_q <= '0; dens_q <= '0; sn_flag_q <= 1'b0;
            err_q <= ERR_NONE; size_q <= '0; addr_q <= '0; serial_q <= '0;
        end else if (launch) begin
            cnt <= '0; sn_flag_q <= 1'b0; err_q <= ERR_NONE;
            size_q <= '0; addr_q <= '0; serial_q <= '0;
        end else if (eng_done) begin
            unique case (state)
                S_ST_OP, S_ID_OP, S_SN_OP: cnt <= '0;
                S_ST_RX: if (eng_rx[0]) err_q <= ERR_BUSY;
                S_ID_RX: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(VENDOR_IDX)) vendor_q <= eng_rx;
                    if (cnt == CNT_W'(DENS_IDX))   dens_q   <= eng_rx;
                    if (cnt == CNT_W'(LAST_ID)) begin
                        if (!vendor_ok)       err_q <= ERR_VENDOR;
                        else if (!density_ok) err_q <= ERR_DENSITY;
                        else begin
                            size_q    <= dec_size;
                            addr_q    <= dec_addr;
                            sn_flag_q <= (eng_rx != 8'h00);
                        end
                    end
                end
                S_SN_RX: begin
                    cnt <= cnt + 1'b1;
                    for (int i = 0; i < SN_BYTES; i++)
                        if (cnt == CNT_W'(SN_BYTES - 1 - i)) serial_q[i*8 +: 8] <= eng_rx;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        spi_cs_n   = !xfer;
        done       = (state == S_FINISH) || (state == S_ABORT);
        valid      = (state == S_FINISH);
        err        = err_q;
        dev_size   = size_q;
        addr_bytes = addr_q;
        serial     = serial_q;
    end

    AST_CS_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk); // R2
    AST_BUSY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ST_RX && eng_done && eng_rx[0]) |=> (state == S_ABORT && err == ERR_BUSY)); // R3
    AST_SIZE_POW2: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $countones(dev_size) == 1); // R7
    AST_ADDR_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (addr_bytes == 2'd2 || addr_bytes == 2'd3)); // R8
    AST_NO_SERIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !sn_flag_q) |-> serial == '0); // R10
    AST_VALID_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (done && err == ERR_NONE)); // R11
endmodule

// File: tb/tb_fram_probe.sv
module tb_fram_probe;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, spi_miso = 1'b0;
    logic spi_sclk, spi_cs_n, spi_mosi, done, valid;
    logic [1:0] err, addr_bytes;
    logic [19:0] dev_size;
    logic [63:0] serial;

    always #(CLK_PERIOD/2) clk = ~clk;

    fram_probe dut (
        .clk(clk), .rst_n(rst_n), .start(start), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .done(done), .valid(valid), .err(err),
        .dev_size(dev_size), .addr_bytes(addr_bytes), .serial(serial)
    );

    int n_checks = 0, n_fail = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // device model
    logic [7:0] m_status;
    logic [7:0] m_id [9];
    logic [7:0] m_sn [8];
    int bitcnt = 0;
    logic [7:0] opc = 8'h00;
    int n_trans = 0, n_st = 0, n_id = 0, n_sn = 0;

    function automatic logic [7:0] resp(input logic [7:0] op, input int idx);
        if (op == 8'h05 && idx == 0) return m_status;
        if (op == 8'h9F && idx < 9)  return m_id[idx];
        if (op == 8'hC3 && idx < 8)  return m_sn[idx];
        return 8'hFF;
    endfunction

    always @(negedge spi_cs_n) begin bitcnt = 0; opc = 8'h00; end
    always @(posedge spi_cs_n) begin
        n_trans++;
        if (opc == 8'h05 && bitcnt == 16) n_st++;
        if (opc == 8'h9F && bitcnt == 80) n_id++;
        if (opc == 8'hC3 && bitcnt == 72) n_sn++;
    end
    always @(posedge spi_sclk) if (!spi_cs_n) begin
        if (bitcnt < 8) opc = {opc[6:0], spi_mosi};
        bitcnt++;
    end
    always @(negedge spi_sclk) if (!spi_cs_n && bitcnt >= 8) begin
        int j;
        logic [7:0] b;
        j = bitcnt - 8;
        b = resp(opc, j / 8);
        spi_miso = b[7 - (j % 8)];
    end

    // scoreboard
    typedef struct packed {
        logic        v;
        logic [1:0]  e;
        logic [19:0] sz;
        logic [1:0]  ab;
        logic [63:0] sn;
        logic [7:0]  nt;
        logic [7:0]  nst;
        logic [7:0]  nid;
        logic [7:0]  nsn;
    } exp_t;
    exp_t q[$];
    string tq[$];

    task automatic probe(input logic [7:0] st, input logic [7:0] vend, input logic [7:0] dens,
                         input logic [7:0] flag, input logic [63:0] snv, input int mid_chk);
        exp_t x;
        string et;
        for (int k = 0; k < 6; k++) m_id[k] = 8'(8'h10 + k * 8'h11);
        m_status = st; m_id[6] = vend; m_id[7] = dens; m_id[8] = flag;
        for (int k = 0; k < 8; k++) m_sn[k] = snv[k*8 +: 8];
        x = '0;
        x.nst = 8'd1;
        if (st[0]) begin
            x.e = 2'd1; x.nt = 8'd1; et = "R3";
        end else if (vend != 8'hC2) begin
            x.e = 2'd2; x.nt = 8'd2; x.nid = 8'd1; et = "R5";
        end else if (dens < 8'h21 || dens > 8'h26) begin
            x.e = 2'd3; x.nt = 8'd2; x.nid = 8'd1; et = "R6";
        end else begin
            x.v = 1'b1; x.nid = 8'd1;
            x.sz = 20'(1024 << (int'(dens) - 'h21 + 4));
            x.ab = (int'(x.sz) > 65536) ? 2'd3 : 2'd2;
            et = "R11";
            if (flag != 8'h00) begin
                x.nt = 8'd3; x.nsn = 8'd1;
                for (int i = 0; i < 8; i++) x.sn[i*8 +: 8] = snv[(7-i)*8 +: 8];
            end else begin
                x.nt = 8'd2;
            end
        end
        q.push_back(x); tq.push_back(et);
        n_trans = 0; n_st = 0; n_id = 0; n_sn = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (mid_chk != 0) begin
            repeat (20) @(negedge clk);
            chk("R11 valid low mid-probe", 64'(valid), 64'd0);
            chk("R11 done low mid-probe", 64'(done), 64'd0);
            chk("R11 serial cleared on start", serial, 64'd0);
        end
        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    logic done_d = 1'b0;
    initial forever begin
        @(negedge clk);
        if (done && !done_d && q.size() > 0) begin
            exp_t x;
            string t;
            x = q.pop_front(); t = tq.pop_front();
            chk("R11 valid", 64'(valid), 64'(x.v));
            chk({t, " err"}, 64'(err), 64'(x.e));
            chk("R7 size", 64'(dev_size), 64'(x.sz));
            chk("R8 addr_bytes", 64'(addr_bytes), 64'(x.ab));
            chk(x.nsn != 0 ? "R9 serial" : "R10 serial", serial, x.sn);
            chk("R2 transaction count", 64'(n_trans), 64'(x.nt));
            chk("R3 status transaction", 64'(n_st), 64'(x.nst));
            chk("R4 ident transaction", 64'(n_id), 64'(x.nid));
            chk(x.nsn != 0 ? "R9 serial transaction" : "R10 no serial transaction",
                64'(n_sn), 64'(x.nsn));
        end
        done_d = done;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cs_n", 64'(spi_cs_n), 64'd1);
        chk("R1 sclk", 64'(spi_sclk), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 valid", 64'(valid), 64'd0);
        chk("R1 err", 64'(err), 64'd0);
        chk("R1 size/addr/serial", {dev_size, addr_bytes, serial[41:0]}, 64'd0);
        probe(8'h00, 8'hC2, 8'h21, 8'h01, 64'h0807060504030201, 0); // R7 smallest
        probe(8'h02, 8'hC2, 8'h26, 8'h00, 64'hDEADBEEF00112233, 0); // R10 largest
        probe(8'h00, 8'hC2, 8'h23, 8'h00, 64'h0, 0);                // R8 64 KiB
        probe(8'h00, 8'hC2, 8'h24, 8'hA5, 64'hF1E2D3C4B5A69788, 1); // R8 128 KiB
        probe(8'h01, 8'hC2, 8'h22, 8'h01, 64'h1, 1);                // R3 busy
        probe(8'h00, 8'h7F, 8'h22, 8'h00, 64'h0, 0);                // R5 vendor
        probe(8'h00, 8'hC2, 8'h20, 8'h00, 64'h0, 0);                // R6 low
        probe(8'h00, 8'hC2, 8'h27, 8'h01, 64'h0, 0);                // R6 high
        probe(8'h00, 8'h00, 8'hFF, 8'h00, 64'h0, 0);                // R5 priority
        probe(8'h00, 8'hC2, 8'h25, 8'h80, 64'h0123456789ABCDEF, 0); // R9
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule